// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a stereo PCM stream made of a bit clock, a word-select line and a single data line. It turns that stream into parallel left/right sample pairs. Left and right words share the data line in turn, and the level of word select tells which channel is being sent. All three serial lines are synchronised into a faster system clock, and bit-clock rising edges are found there. One shift engine then recovers each word in the selected framing. The framing can be I2S, left-justified, or right-justified with 16, 18 or 20 bits.

The framing comes either from a 3-bit control code or from a 2-bit static pin code. A mode input picks which of the two is used. Every sample leaves the block 20 bits wide. In right-justified framing it is sign-extended from the word's top bit. In the other framings it is MSB-aligned. Each complete stereo pair is offered on a valid/ready output. A pair is held until it is accepted. If the next pair completes while the held one is still waiting, the new pair is dropped, so the consumer always sees whole pairs in order.

Top module: `srx_rx`

## Requirements
- R1: While reset is asserted and after it is released, `pair_valid` is low and both sample outputs are zero until the first pair is complete.
- R2: With `pin_mode` high the framing follows `pin_fmt`: 00 I2S, 01 right-justified 16, 10 right-justified 18, 11 right-justified 20. With `pin_mode` low it follows `ctl_fmt`: 000 I2S, 001/010/011 right-justified 16/18/20, 100 left-justified, and 101, 110 and 111 behave as I2S.
- R3: Data is sampled on rising edges of `bit_clk`. `word_sel` changes only while `bit_clk` is low, with low meaning left and high meaning right.
- R4: In I2S framing the MSB is the bit on the second rising edge after `word_sel` changes, and the following bits come MSB first.
- R5: In left-justified framing the MSB is the bit on the first rising edge after `word_sel` changes.
- R6: In I2S and left-justified framing, bits after the twentieth of a channel are ignored, and a word shorter than 20 bits is filled with zeros at the LSB end.
- R7: In right-justified framing with N bits, the sample is made of the last N bits before `word_sel` changes, sign-extended from bit N-1. Earlier bits in the channel are ignored.
- R8: A pair is produced when a right word completes, and only if the left word just before it also completed. A word already in progress at reset release is never produced.
- R9: Once `pair_valid` is high it stays high, with stable data, until a cycle where `pair_ready` is high. That cycle transfers the pair.
- R10: A pair that completes while the previous pair is still waiting for acceptance is discarded.
- R11: `pair_left` and `pair_right` change only when a new pair is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_clk | input | 1 | Serial bit clock (asynchronous) |
| word_sel | input | 1 | Channel select: 0 left, 1 right |
| ser_data | input | 1 | Serial data |
| pin_mode | input | 1 | 1 selects `pin_fmt`, 0 selects `ctl_fmt` |
| ctl_fmt | input | 3 | Framing code from the control port |
| pin_fmt | input | 2 | Framing code from static pins |
| pair_valid | output | 1 | A stereo pair is available |
| pair_ready | input | 1 | The consumer accepts the pair |
| pair_left | output | 20 | Left sample |
| pair_right | output | 20 | Right sample |

## Verification
The data pattern stays similar across tests, but the framing changes: I2S, left-justified with 24-bit and 16-bit channels, and each right-justified length with all-ones filler ahead of the word. These runs tell apart a one-bit misalignment, leakage of extra or filler bits, and sign extension taken from the wrong bit. Pin-selected and unused control codes are driven against a conflicting other source, which shows which code is actually in effect. A stream that starts in the middle of a word checks that partial words are discarded. A run with the consumer stalled shows the hold-and-drop behaviour at the output.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    FMT_I2S  = 3'd0,
    FMT_RJ16 = 3'd1,
    FMT_RJ18 = 3'd2,
    FMT_RJ20 = 3'd3,
    FMT_LJ   = 3'd4
  } srx_fmt_e;

  // R2: resolve the active framing; unused control codes fall back to I2S
  function automatic srx_fmt_e srx_pick_fmt(input logic pin_mode,
                                            input logic [2:0] ctl,
                                            input logic [1:0] pins);
    if (pin_mode) return srx_fmt_e'({1'b0, pins});
    case (ctl)
      3'd1:    return FMT_RJ16;
      3'd2:    return FMT_RJ18;
      3'd3:    return FMT_RJ20;
      3'd4:    return FMT_LJ;
      default: return FMT_I2S;
    endcase
  endfunction

  function automatic logic srx_is_rj(input srx_fmt_e f);
    return (f == FMT_RJ16) || (f == FMT_RJ18) || (f == FMT_RJ20);
  endfunction

  function automatic int srx_rj_len(input srx_fmt_e f);
    case (f)
      FMT_RJ16: return 16;
      FMT_RJ18: return 18;
      default:  return 20;
    endcase
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2,
  parameter int NSIG   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSIG-1:0] d,
  output logic [NSIG-1:0] q
);
  logic [NSIG-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[s] <= '0;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/srx_shift_engine.sv
module srx_shift_engine
  import srx_pkg::*;
#(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_stb,
  input  logic         ws_i,
  input  logic         sd_i,
  input  srx_fmt_e     fmt,
  output logic         word_stb,
  output logic         word_ch,
  output logic [W-1:0] word_data
);
  localparam int CW = $clog2(W + 1);

  logic         ws_d1, ws_d2;
  logic [1:0]   seen;
  logic [W-1:0] acc, sr, rj_word;
  logic [CW-1:0] cnt;
  logic         la_go, ra_go;
  logic         is_i2s, is_rj, ws_eff, ws_eff_old, eff_ok, la_edge, ra_edge;

  always_comb begin
    int rj_sh;
    is_i2s     = (fmt == FMT_I2S);
    is_rj      = srx_is_rj(fmt);
    // I2S is left-justified framing seen through a one-bit-late word select
    ws_eff     = is_i2s ? ws_d1 : ws_i;
    ws_eff_old = is_i2s ? ws_d2 : ws_d1;
    eff_ok     = is_i2s ? (seen == 2'd2) : (seen != 2'd0);
    la_edge    = bit_stb & eff_ok & (ws_eff ^ ws_eff_old);
    ra_edge    = bit_stb & (seen != 2'd0) & (ws_i ^ ws_d1);
    rj_sh      = W - srx_rj_len(fmt);
    rj_word    = $unsigned($signed(sr << rj_sh) >>> rj_sh);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_d1 <= 1'b0; ws_d2 <= 1'b0; seen <= '0;
      acc <= '0; sr <= '0; cnt <= '0;
      la_go <= 1'b0; ra_go <= 1'b0;
      word_stb <= 1'b0; word_ch <= 1'b0; word_data <= '0;
    end else begin
      word_stb <= 1'b0;
      if (bit_stb) begin
        ws_d1 <= ws_i;
        ws_d2 <= ws_d1;
        if (seen != 2'd2) seen <= seen + 2'd1;
        sr <= {sr[W-2:0], sd_i};
        if (la_edge) begin
          acc <= {{(W-1){1'b0}}, sd_i};
          cnt <= CW'(1);
        end else if (cnt < CW'(W)) begin
          acc <= {acc[W-2:0], sd_i};
          cnt <= cnt + CW'(1);
        end
        if (la_edge) la_go <= 1'b1;
        if (ra_edge) ra_go <= 1'b1;
        if (is_rj) begin
          word_stb  <= ra_edge & ra_go;
          word_ch   <= ws_d1;
          word_data <= rj_word;
        end else begin
          word_stb  <= la_edge & la_go;
          word_ch   <= ws_eff_old;
          word_data <= acc << (W - int'(cnt));
        end
      end
    end
  end
endmodule

// File: rtl/srx_pair_out.sv
module srx_pair_out #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_stb,
  input  logic         word_ch,
  input  logic [W-1:0] word_data,
  input  logic         pair_ready,
  output logic         pair_valid,
  output logic [W-1:0] pair_left,
  output logic [W-1:0] pair_right,
  output logic         pair_done
);
  logic [W-1:0] left_hold;
  logic         left_ok;

  assign pair_done = word_stb & word_ch & left_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_hold <= '0; left_ok <= 1'b0;
      pair_valid <= 1'b0; pair_left <= '0; pair_right <= '0;
    end else begin
      if (word_stb) begin
        if (!word_ch) begin
          left_hold <= word_data;
          left_ok   <= 1'b1;
        end else begin
          left_ok   <= 1'b0;
        end
      end
      if (pair_done && (!pair_valid || pair_ready)) begin
        pair_valid <= 1'b1;
        pair_left  <= left_hold;
        pair_right <= word_data;
      end else if (pair_ready) begin
        pair_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/srx_rx.sv
module srx_rx
  import srx_pkg::*;
#(
  parameter int SAMPLE_W    = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_clk,
  input  logic                word_sel,
  input  logic                ser_data,
  input  logic                pin_mode,
  input  logic [2:0]          ctl_fmt,
  input  logic [1:0]          pin_fmt,
  output logic                pair_valid,
  input  logic                pair_ready,
  output logic [SAMPLE_W-1:0] pair_left,
  output logic [SAMPLE_W-1:0] pair_right
);
  logic [2:0]          sync_q;
  logic                bclk_s, ws_s, sd_s, bclk_q, bit_stb;
  srx_fmt_e            fmt;
  logic                word_stb, word_ch, pair_done;
  logic [SAMPLE_W-1:0] word_data;

  srx_sync #(.STAGES(SYNC_STAGES), .NSIG(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({bit_clk, word_sel, ser_data}), .q(sync_q)
  );
  assign {bclk_s, ws_s, sd_s} = sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) bclk_q <= 1'b0;
    else        bclk_q <= bclk_s;
  end
  assign bit_stb = bclk_s & ~bclk_q;
  assign fmt     = srx_pick_fmt(pin_mode, ctl_fmt, pin_fmt);

  srx_shift_engine #(.W(SAMPLE_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .ws_i(ws_s), .sd_i(sd_s),
    .fmt(fmt), .word_stb(word_stb), .word_ch(word_ch), .word_data(word_data)
  );

  srx_pair_out #(.W(SAMPLE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .word_ch(word_ch),
    .word_data(word_data), .pair_ready(pair_ready), .pair_valid(pair_valid),
    .pair_left(pair_left), .pair_right(pair_right), .pair_done(pair_done)
  );
endmodule

// File: rtl/srx_rx_chk.sv
module srx_rx_chk #(
  parameter int W = 20
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pair_valid,
  input logic         pair_ready,
  input logic [W-1:0] pair_left,
  input logic [W-1:0] pair_right,
  input logic         pair_done
);
  // R9
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid && !pair_ready |=> pair_valid && $stable(pair_left) && $stable(pair_right));

  // R9
  accept_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid && pair_ready && !pair_done |=> !pair_valid);

  // R8
  rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pair_valid) |-> $past(pair_done));

  // R11
  data_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(pair_left) && $stable(pair_right)) |-> $past(pair_done));

  // R10
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_done && pair_valid && !pair_ready |=> $stable(pair_right));
endmodule

bind srx_rx srx_rx_chk #(.W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid), .pair_ready(pair_ready),
  .pair_left(pair_left), .pair_right(pair_right), .pair_done(pair_done)
);

// File: tb/tb_srx_rx.sv
module tb_srx_rx;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, bit_clk, word_sel, ser_data, pin_mode, pair_ready, pair_valid;
  logic [2:0] ctl_fmt;
  logic [1:0] pin_fmt;
  logic [19:0] pair_left, pair_right;

  srx_rx dut (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .word_sel(word_sel),
    .ser_data(ser_data), .pin_mode(pin_mode), .ctl_fmt(ctl_fmt), .pin_fmt(pin_fmt),
    .pair_valid(pair_valid), .pair_ready(pair_ready),
    .pair_left(pair_left), .pair_right(pair_right)
  );

  int n_chk = 0, n_fail = 0, got_n = 0;
  logic [19:0] got_l [16];
  logic [19:0] got_r [16];
  logic [31:0] tx_l [4];
  logic [31:0] tx_r [4];

  always @(negedge clk) begin
    if (!rst_n) got_n = 0;
    else if (pair_valid && pair_ready && got_n < 16) begin
      got_l[got_n] = pair_left;
      got_r[got_n] = pair_right;
      got_n++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // kind: 0 I2S, 1 left-justified, 2 right-justified
  function automatic logic [19:0] exp_word(input int kind, input logic [31:0] w, input int nb);
    logic [31:0] m;
    logic [31:0] s;
    m = (nb >= 32) ? w : (w & ((32'd1 << nb) - 32'd1));
    if (kind == 2) begin
      s = m << (32 - nb);
      return 20'($signed(s) >>> (32 - nb));
    end
    if (nb >= 20) return 20'(m >> (nb - 20));
    return 20'(m << (20 - nb));
  endfunction

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; bit_clk = 1'b0; word_sel = 1'b1; ser_data = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_bit(input logic ch, input logic d);
    bit_clk = 1'b0; word_sel = ch; ser_data = d;
    repeat (HALF) @(negedge clk);
    bit_clk = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_slot(input logic ch, input int kind, input int slen,
                           input logic [31:0] w, input int nb);
    for (int p = 0; p < slen; p++) begin
      logic d;
      int q;
      d = 1'b1;
      if (kind == 0) begin
        q = p - 1;
        if (q >= 0 && q < nb) d = w[nb-1-q];
      end else if (kind == 1) begin
        if (p < nb) d = w[nb-1-p];
      end else begin
        q = p - (slen - nb);
        if (q >= 0) d = w[nb-1-q];
      end
      send_bit(ch, d);
    end
  endtask

  task automatic fill_tx(input logic [31:0] seed);
    for (int f = 0; f < 4; f++) begin
      tx_l[f] = (seed * (f + 3)) ^ 32'h8421_7E5B;
      tx_r[f] = (seed * (f + 7)) ^ 32'h3C5A_F00D;
    end
  endtask

  task automatic send_frames(input int kind, input int slen, input int nb, input int nfr);
    for (int f = 0; f < nfr; f++) begin
      send_slot(1'b0, kind, slen, tx_l[f], nb);
      send_slot(1'b1, kind, slen, tx_r[f], nb);
    end
    send_slot(1'b0, kind, slen, 32'h0, nb);
    repeat (10) @(negedge clk);
  endtask

  task automatic run_fmt(input string tag, input logic pm, input logic [2:0] cf,
                         input logic [1:0] pf, input int kind, input int slen,
                         input int nb, input logic [31:0] seed);
    pin_mode = pm; ctl_fmt = cf; pin_fmt = pf; pair_ready = 1'b1;
    do_reset;
    fill_tx(seed);
    send_slot(1'b1, kind, slen, 32'h0, nb);
    send_frames(kind, slen, nb, 3);
    chk({tag, " R8 pair count"}, got_n, 3);
    for (int f = 0; f < 3; f++) begin
      chk({tag, " R3 left"},  got_l[f], exp_word(kind, tx_l[f], nb));
      chk({tag, " R3 right"}, got_r[f], exp_word(kind, tx_r[f], nb));
    end
  endtask

  task automatic t_reset;
    do_reset;
    chk("R1 valid after reset", pair_valid, 0);
    chk("R1 left after reset", pair_left, 0);
    chk("R1 right after reset", pair_right, 0);
  endtask

  task automatic t_partial;
    pin_mode = 1'b0; ctl_fmt = 3'd4; pair_ready = 1'b1;
    do_reset;
    fill_tx(32'h0BAD_F00D);
    send_slot(1'b0, 1, 10, 32'h3FF, 10);
    send_slot(1'b1, 1, 32, 32'h000A_BCDE, 20);
    send_frames(1, 32, 20, 2);
    chk("R8 partial start count", got_n, 2);
    chk("R8 partial start left", got_l[0], exp_word(1, tx_l[0], 20));
    chk("R8 partial start right", got_r[0], exp_word(1, tx_r[0], 20));
  endtask

  task automatic t_backpressure;
    pin_mode = 1'b0; ctl_fmt = 3'd4; pair_ready = 1'b0;
    do_reset;
    fill_tx(32'h1357_2468);
    send_slot(1'b1, 1, 32, 32'h0, 20);
    send_frames(1, 32, 20, 2);
    chk("R9 valid held while stalled", pair_valid, 1);
    chk("R10 held left kept", pair_left, exp_word(1, tx_l[0], 20));
    chk("R10 held right kept", pair_right, exp_word(1, tx_r[0], 20));
    chk("R9 nothing transferred", got_n, 0);
    pair_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 one pair transferred", got_n, 1);
    chk("R9 transferred left", got_l[0], exp_word(1, tx_l[0], 20));
    chk("R9 valid drops after accept", pair_valid, 0);
    repeat (20) @(negedge clk);
    chk("R11 left stable when idle", pair_left, exp_word(1, tx_l[0], 20));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_clk = 1'b0; word_sel = 1'b1; ser_data = 1'b0;
    pin_mode = 1'b0; ctl_fmt = 3'd0; pin_fmt = 2'd0; pair_ready = 1'b1;
    run_fmt("R4 i2s", 1'b0, 3'd0, 2'd3, 0, 32, 20, 32'h1234_5678);
    t_reset;
    run_fmt("R5 R6 lj long word", 1'b0, 3'd4, 2'd1, 1, 32, 24, 32'h9E37_79B9);
    run_fmt("R6 lj short slot", 1'b0, 3'd4, 2'd0, 1, 16, 16, 32'h7F4A_7C15);
    run_fmt("R7 rj16", 1'b0, 3'd1, 2'd0, 2, 32, 16, 32'hC2B2_AE35);
    run_fmt("R7 rj18", 1'b0, 3'd2, 2'd0, 2, 32, 18, 32'h27D4_EB2F);
    run_fmt("R7 rj20", 1'b0, 3'd3, 2'd0, 2, 32, 20, 32'h1656_67B1);
    run_fmt("R2 pins rj18", 1'b1, 3'd4, 2'd2, 2, 32, 18, 32'hDEAD_BEEF);
    run_fmt("R2 pins i2s", 1'b1, 3'd3, 2'd0, 0, 32, 20, 32'h0F1E_2D3C);
    run_fmt("R2 unused code", 1'b0, 3'd6, 2'd3, 0, 32, 20, 32'hA5A5_5A5A);
    t_partial;
    t_backpressure;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule